// File: doc/BRIEF.md
# Triggered Scan Acquisition Controller

This block sequences analog-to-digital conversions for one channel or for a scanned list of channels. Software fills a small configuration memory. Each entry holds a channel number, a gain code, a bipolar/unipolar flag and an end-of-scan marker. Software then starts a run, either with a start strobe or with a falling edge on an active-low external trigger. The ADC, the sample-interval timebase, the result FIFO and the host bus all sit outside the block. The timebase delivers one `sample_tick` per sample interval, and the ADC answers each conversion request with a one-cycle `conv_done`.

On each tick during a run, the block issues a one-cycle conversion request. The current entry is held on the `cur_*` outputs. When the conversion completes, the block pulses a scan clock and fetches the next entry; an entry carrying the end marker sends the scan back to entry 0. Each completed conversion decrements a sample counter, which has a 16-bit mode and a cascaded 32-bit mode. When the counter reaches zero, the run ends and a completion flag is raised.

In pre-trigger mode, conversions begin at the first trigger but are not counted until a second trigger arrives. Software can ignore external triggers entirely, and it can block new runs until it acknowledges the last completion.

Top module: `scan_acq_ctrl`

## Requirements
- R1: A run starts, with `busy` rising one cycle later, when `start` is high at a clock edge, or at the first edge where `ext_trig_n` is sampled low after being sampled high. A trigger that arrives while a run is in progress does not start a new one.
- R2: With `pretrig` set at start, conversions run from the first trigger. Only conversions that complete after a second trigger (start strobe or external edge) are counted, so exactly N further conversions follow that second trigger.
- R3: While `trig_dis` is high, falling edges on `ext_trig_n` have no effect; `busy` stays low and no conversion is issued.
- R4: While `retrig_dis` is high and `done` is set, both start strobes and trigger edges are ignored. `done_ack` clears `done`, after which a start is accepted again.
- R5: With `cnt32` low, a run performs `samp_count[15:0]` conversions; bits 31:16 are ignored and a value of 0 means 65536. With `cnt32` high, the full 32-bit value is the count.
- R6: Configuration entries are 9 bits: channel in [3:0], gain in [6:4], bipolar in [7] and end marker in [8]. `cfg_wr` stores the entry at the write pointer and advances it. During a run, each completed conversion loads the next entry; after an entry with bit 8 set, the scan continues at entry 0.
- R7: `cfg_clr` returns both the write pointer and the read pointer to entry 0. Each `cfg_load` copies the entry at the read pointer to `cur_*` and advances the read pointer, so a scan can begin at any loaded position.
- R8: `conv_pulse` is high for one cycle, one cycle after a `sample_tick` that arrives while running with no conversion pending. `scan_clk` is high for one cycle, one cycle after each accepted `conv_done`, so it pulses once per conversion. The two are never high together.
- R9: A `sample_tick` that arrives while a conversion is still pending sets `overrun` and issues no request. `overrun` stays set until `ovr_clr`.
- R10: When the count is used up, `busy` falls, `done` rises and no further requests are issued. `conv_pulse` is only ever seen while `busy` is high, and a newly accepted start clears `done`.
- R11: After reset, `busy`, `done`, `overrun`, `conv_pulse` and `scan_clk` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_clr | input | 1 | Reset both configuration pointers to entry 0 |
| cfg_wr | input | 1 | Write `cfg_wdata` at the write pointer |
| cfg_wdata | input | 9 | Entry: {last, bipolar, gain[2:0], chan[3:0]} |
| cfg_load | input | 1 | Fetch the entry at the read pointer into `cur_*` |
| start | input | 1 | Software start / second-trigger strobe |
| ext_trig_n | input | 1 | External active-low trigger |
| trig_dis | input | 1 | Ignore external trigger edges |
| retrig_dis | input | 1 | Block new runs while `done` is unacknowledged |
| pretrig | input | 1 | Pre-trigger mode select |
| cnt32 | input | 1 | Select the 32-bit cascaded count |
| samp_count | input | 32 | Sample count, latched at start |
| done_ack | input | 1 | Acknowledge and clear `done` |
| ovr_clr | input | 1 | Clear `overrun` |
| sample_tick | input | 1 | Sample-interval tick |
| conv_done | input | 1 | Conversion-complete handshake |
| conv_pulse | output | 1 | Conversion request pulse |
| scan_clk | output | 1 | One pulse per completed conversion |
| cur_chan | output | 4 | Channel of the current entry |
| cur_gain | output | 3 | Gain code of the current entry |
| cur_bip | output | 1 | Bipolar flag of the current entry |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run completed, not yet acknowledged |
| overrun | output | 1 | Sticky overrun flag |

## Verification
A wrong configuration pointer shows up at the very next conversion request, because `cur_*` then carries the wrong channel or gain; the scoreboard compares every request against the expected scan order. A miscounted sample counter does not show until the run ends, when `done` rises one conversion early or late. The bench therefore counts the requests issued in each run, including a full 65536-sample run. Mishandled trigger gating shows within a cycle as an unexpected rise of `busy`.

// File: rtl/scan_pkg.sv
package scan_pkg;
  localparam int CH_W   = 4;
  localparam int GAIN_W = 3;

  typedef struct packed {
    logic              last;
    logic              bip;
    logic [GAIN_W-1:0] gain;
    logic [CH_W-1:0]   chan;
  } ent_t;

  localparam int ENT_W = $bits(ent_t);
endpackage

// File: rtl/scan_trig.sv
module scan_trig (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic ext_trig_n,
  input  logic trig_dis,
  output logic evt
);
  logic trig_q;

  always_ff @(posedge clk) begin
    if (rst) trig_q <= 1'b1;
    else     trig_q <= ext_trig_n;
  end

  // falling edge of the external line, gated by the disable bit
  assign evt = start | (~trig_dis & trig_q & ~ext_trig_n);
endmodule

// File: rtl/scan_cfg_mem.sv
module scan_cfg_mem
  import scan_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic wr,
  input  ent_t wdata,
  input  logic load,
  input  logic adv,
  output ent_t cur
);
  localparam int AW = $clog2(DEPTH);

  ent_t          mem [DEPTH];
  ent_t          cur_q;
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic [AW-1:0] raddr;
  logic          fetch;

  assign fetch = load | adv;
  assign raddr = (adv && cur_q.last) ? '0 : rd_ptr;

  // write port and registered read port, no reset: maps onto block RAM
  always_ff @(posedge clk) begin
    if (wr)    mem[wr_ptr] <= wdata;
    if (fetch) cur_q <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (wr)    wr_ptr <= wr_ptr + 1'b1;
      if (fetch) rd_ptr <= raddr + 1'b1;
    end
  end

  assign cur = cur_q;
endmodule

// File: rtl/scan_count.sv
module scan_count #(
  parameter int STG_W = 16,
  parameter int NSTG  = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load,
  input  logic                  wide,
  input  logic [STG_W*NSTG-1:0] val,
  input  logic                  dec,
  output logic                  last
);
  logic [NSTG:0]   brw;
  logic [NSTG-1:0] nz;
  logic [NSTG-1:0] eq1;
  logic            wide_q;

  always_ff @(posedge clk) begin
    if (rst)       wide_q <= 1'b0;
    else if (load) wide_q <= wide;
  end

  assign brw[0] = 1'b1;

  for (genvar i = 0; i < NSTG; i++) begin : g_stg
    logic [STG_W-1:0] q;
    logic             en;

    if (i == 0) begin : g_lo
      assign en = 1'b1;
    end else begin : g_hi
      assign en = wide_q;
    end

    always_ff @(posedge clk) begin
      if (rst)
        q <= '0;
      else if (load)
        q <= (i == 0 || wide) ? val[i*STG_W +: STG_W] : '0;
      else if (dec && brw[i] && en)
        q <= q - 1'b1;
    end

    assign brw[i+1] = brw[i] & (q == '0);
    assign nz[i]    = |q;
    assign eq1[i]   = (q == STG_W'(1));
  end

  assign last = eq1[0] & ~|nz[NSTG-1:1];
endmodule

// File: rtl/scan_acq_ctrl.sv
module scan_acq_ctrl
  import scan_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int STG_W = 16,
  parameter int NSTG  = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_clr,
  input  logic                  cfg_wr,
  input  logic [ENT_W-1:0]      cfg_wdata,
  input  logic                  cfg_load,
  input  logic                  start,
  input  logic                  ext_trig_n,
  input  logic                  trig_dis,
  input  logic                  retrig_dis,
  input  logic                  pretrig,
  input  logic                  cnt32,
  input  logic [STG_W*NSTG-1:0] samp_count,
  input  logic                  done_ack,
  input  logic                  ovr_clr,
  input  logic                  sample_tick,
  input  logic                  conv_done,
  output logic                  conv_pulse,
  output logic                  scan_clk,
  output logic [CH_W-1:0]       cur_chan,
  output logic [GAIN_W-1:0]     cur_gain,
  output logic                  cur_bip,
  output logic                  busy,
  output logic                  done,
  output logic                  overrun
);
  logic evt, accept, arm2, cd, fin, cnt_last, issue;
  logic running, counting, pend, done_q, ovr_q, conv_q, sclk_q;
  ent_t cur;

  scan_trig u_trig (
    .clk(clk), .rst(rst), .start(start), .ext_trig_n(ext_trig_n),
    .trig_dis(trig_dis), .evt(evt)
  );

  scan_cfg_mem #(.DEPTH(DEPTH)) u_mem (
    .clk(clk), .rst(rst), .clr(cfg_clr), .wr(cfg_wr), .wdata(ent_t'(cfg_wdata)),
    .load(cfg_load), .adv(cd), .cur(cur)
  );

  scan_count #(.STG_W(STG_W), .NSTG(NSTG)) u_cnt (
    .clk(clk), .rst(rst), .load(accept), .wide(cnt32), .val(samp_count),
    .dec(cd & counting), .last(cnt_last)
  );

  assign accept = evt & ~running & ~(retrig_dis & done_q);
  assign arm2   = evt & running & ~counting;
  assign cd     = conv_done & pend;
  assign fin    = cd & counting & cnt_last;
  assign issue  = running & sample_tick & ~pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      running  <= 1'b0;
      counting <= 1'b0;
      pend     <= 1'b0;
      done_q   <= 1'b0;
      ovr_q    <= 1'b0;
      conv_q   <= 1'b0;
      sclk_q   <= 1'b0;
    end else begin
      conv_q <= issue;
      sclk_q <= cd;

      if (done_ack) done_q <= 1'b0;
      if (accept) begin
        running  <= 1'b1;
        counting <= ~pretrig;
        done_q   <= 1'b0;
      end else if (fin) begin
        running  <= 1'b0;
        counting <= 1'b0;
        done_q   <= 1'b1;
      end else if (arm2) begin
        counting <= 1'b1;
      end

      if (issue)   pend <= 1'b1;
      else if (cd) pend <= 1'b0;

      if (ovr_clr) ovr_q <= 1'b0;
      if (running && sample_tick && pend) ovr_q <= 1'b1;
    end
  end

  assign conv_pulse = conv_q;
  assign scan_clk   = sclk_q;
  assign busy       = running;
  assign done       = done_q;
  assign overrun    = ovr_q;
  assign cur_chan   = cur.chan;
  assign cur_gain   = cur.gain;
  assign cur_bip    = cur.bip;
endmodule

// File: rtl/scan_acq_chk.sv
module scan_acq_chk (
  input logic clk,
  input logic rst,
  input logic start,
  input logic ext_trig_n,
  input logic trig_dis,
  input logic retrig_dis,
  input logic ovr_clr,
  input logic conv_pulse,
  input logic scan_clk,
  input logic busy,
  input logic done,
  input logic overrun
);
  a_r1_busy_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(start) || !$past(ext_trig_n)));

  a_r3_trig_ignored: assert property (@(posedge clk) disable iff (rst)
    ($past(trig_dis) && !$past(start) && !$past(busy)) |-> !busy);

  a_r4_retrig_block: assert property (@(posedge clk) disable iff (rst)
    ($past(done) && $past(retrig_dis)) |-> !busy);

  a_r8_sclk_vs_conv: assert property (@(posedge clk) disable iff (rst)
    !(scan_clk && conv_pulse));

  a_r8_sclk_single: assert property (@(posedge clk) disable iff (rst)
    scan_clk |=> !scan_clk);

  a_r9_ovr_sticky: assert property (@(posedge clk) disable iff (rst)
    ($past(overrun) && !$past(ovr_clr)) |-> overrun);

  a_r10_pulse_in_run: assert property (@(posedge clk) disable iff (rst)
    conv_pulse |-> busy);

  a_r10_done_excl: assert property (@(posedge clk) disable iff (rst)
    !(done && busy));
endmodule

bind scan_acq_ctrl scan_acq_chk u_chk (
  .clk(clk), .rst(rst), .start(start), .ext_trig_n(ext_trig_n),
  .trig_dis(trig_dis), .retrig_dis(retrig_dis), .ovr_clr(ovr_clr),
  .conv_pulse(conv_pulse), .scan_clk(scan_clk), .busy(busy),
  .done(done), .overrun(overrun)
);

// File: tb/sim_scan_acq_ctrl.sv
`timescale 1ns/1ps
module sim_scan_acq_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_clr = 0, cfg_wr = 0, cfg_load = 0, start = 0, ext_trig_n = 1;
  logic trig_dis = 0, retrig_dis = 0, pretrig = 0, cnt32 = 0;
  logic done_ack = 0, ovr_clr = 0;
  logic [8:0]  cfg_wdata = '0;
  logic [31:0] samp_count = '0;
  logic sample_tick, conv_done, conv_pulse, scan_clk, cur_bip, busy, done, overrun;
  logic [3:0] cur_chan;
  logic [2:0] cur_gain;

  always #2 clk = ~clk;

  scan_acq_ctrl u0 (
    .clk(clk), .rst(rst), .cfg_clr(cfg_clr), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_load(cfg_load), .start(start), .ext_trig_n(ext_trig_n), .trig_dis(trig_dis),
    .retrig_dis(retrig_dis), .pretrig(pretrig), .cnt32(cnt32), .samp_count(samp_count),
    .done_ack(done_ack), .ovr_clr(ovr_clr), .sample_tick(sample_tick),
    .conv_done(conv_done), .conv_pulse(conv_pulse), .scan_clk(scan_clk),
    .cur_chan(cur_chan), .cur_gain(cur_gain), .cur_bip(cur_bip),
    .busy(busy), .done(done), .overrun(overrun)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // tick generator and ADC responder
  int  per = 8, lat = 3;
  bit  tick_en = 1, fast = 0;
  int  tcnt = 0, dly = 0;
  logic done_r = 0;
  always @(posedge clk) begin
    if (rst) begin
      tcnt <= 0; sample_tick <= 1'b0; dly <= 0; done_r <= 1'b0;
    end else begin
      sample_tick <= tick_en && (tcnt == 0);
      tcnt <= (tcnt >= per - 1) ? 0 : tcnt + 1;
      if (conv_pulse) dly <= lat;
      else if (dly != 0) dly <= dly - 1;
      done_r <= (dly == 1);
    end
  end
  assign conv_done = fast ? conv_pulse : done_r;

  // configuration image held by the bench
  logic [3:0] e_ch [4] = '{4'd2, 4'd5, 4'd9, 4'd7};
  logic [2:0] e_g  [4] = '{3'd1, 3'd3, 3'd6, 3'd2};
  logic       e_b  [4] = '{1'b1, 1'b0, 1'b1, 1'b0};
  logic       e_l  [4] = '{1'b0, 1'b0, 1'b1, 1'b1};

  logic [7:0] expq [$];
  bit chk_en = 1;
  int nconv = 0, nsclk = 0;
  logic prev_tick = 0, prev_done = 0;

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (conv_pulse) begin
        nconv++;
        chk(prev_tick, "R8 request follows tick", 0, 1);
        if (chk_en) begin
          if (expq.size() == 0) chk(0, "R6 unexpected request", cur_chan, 0);
          else begin
            logic [7:0] e;
            e = expq.pop_front();
            chk({cur_bip, cur_gain, cur_chan} == e, "R6 entry order",
                {cur_bip, cur_gain, cur_chan}, e);
          end
        end
      end
      if (scan_clk) begin
        nsclk++;
        chk(prev_done, "R8 scan clock follows completion", 0, 1);
      end
    end
    prev_tick = sample_tick;
    prev_done = conv_done;
  end

  task automatic push_seq(input int idx, input int n);
    int k = idx;
    for (int i = 0; i < n; i++) begin
      expq.push_back({e_b[k], e_g[k], e_ch[k]});
      k = e_l[k] ? 0 : k + 1;
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start();
    start = 1; cyc(1); start = 0;
  endtask

  task automatic pulse_ext();
    ext_trig_n = 0; cyc(2); ext_trig_n = 1;
  endtask

  task automatic wait_done(input int maxc, input string req);
    int c = 0;
    while (!done && c < maxc) begin cyc(1); c++; end
    chk(done, req, done, 1);
  endtask

  initial begin
    int base;
    cyc(4); rst = 0; cyc(1);
    // R11 reset state
    chk(!busy, "R11 busy", busy, 0);
    chk(!done, "R11 done", done, 0);
    chk(!overrun, "R11 overrun", overrun, 0);
    chk(!conv_pulse && !scan_clk, "R11 pulses", conv_pulse, 0);

    // R6/R7 program four entries, load the first
    cfg_clr = 1; cyc(1); cfg_clr = 0;
    for (int i = 0; i < 4; i++) begin
      cfg_wr = 1; cfg_wdata = {e_l[i], e_b[i], e_g[i], e_ch[i]}; cyc(1);
    end
    cfg_wr = 0;
    cfg_load = 1; cyc(1); cfg_load = 0; cyc(1);

    // R1 start strobe, R6 wrap on marker, R10 completion
    push_seq(0, 7); samp_count = 7; base = nconv;
    pulse_start();
    chk(busy, "R1 busy after start", busy, 1);
    wait_done(2000, "R10 run completes");
    cyc(30);
    chk(!busy, "R10 busy low", busy, 0);
    chk(nconv - base == 7, "R10 request count", nconv - base, 7);
    chk(expq.size() == 0, "R6 scoreboard drained", expq.size(), 0);
    chk(nsclk == 7, "R8 scan clocks", nsclk, 7);

    // R7 start from second entry, R1 external edge, R10 done cleared on start
    cfg_clr = 1; cyc(1); cfg_clr = 0;
    cfg_load = 1; cyc(2); cfg_load = 0; cyc(1);
    push_seq(1, 4); samp_count = 4; base = nconv;
    pulse_ext();
    chk(busy, "R1 busy after edge", busy, 1);
    chk(!done, "R10 done cleared by start", done, 0);
    wait_done(2000, "R7 run completes");
    cyc(20);
    chk(nconv - base == 4, "R5 count of four", nconv - base, 4);
    chk(expq.size() == 0, "R7 scoreboard drained", expq.size(), 0);

    // R3 external edges ignored
    trig_dis = 1; base = nconv;
    pulse_ext(); cyc(40);
    chk(!busy, "R3 busy stays low", busy, 0);
    chk(nconv == base, "R3 no requests", nconv - base, 0);
    trig_dis = 0;

    // R4 retrigger blocked until acknowledge
    retrig_dis = 1;
    pulse_start(); cyc(20);
    chk(!busy, "R4 start blocked", busy, 0);
    chk(done, "R4 done held", done, 1);
    done_ack = 1; cyc(1); done_ack = 0;
    chk(!done, "R4 ack clears done", done, 0);
    push_seq(2, 2); samp_count = 2;
    pulse_start();
    chk(busy, "R4 start after ack", busy, 1);
    wait_done(2000, "R4 run completes");
    retrig_dis = 0; cyc(20);

    // R2 pre-trigger: no counting until second edge
    chk_en = 0; pretrig = 1; samp_count = 3;
    pulse_ext();
    base = nsclk;
    while (nsclk - base < 4) cyc(1);
    chk(busy && !done, "R2 still running before second edge", busy, 1);
    ext_trig_n = 0; base = nconv; cyc(2); ext_trig_n = 1;
    wait_done(2000, "R2 run completes");
    cyc(30);
    chk(nconv - base == 3, "R2 counted after second edge", nconv - base, 3);
    pretrig = 0;

    // R9 overrun
    lat = 12; samp_count = 2;
    pulse_start();
    wait_done(3000, "R9 run completes");
    chk(overrun, "R9 overrun set", overrun, 1);
    cyc(5);
    chk(overrun, "R9 overrun held", overrun, 1);
    ovr_clr = 1; cyc(1); ovr_clr = 0; cyc(1);
    chk(!overrun, "R9 overrun cleared", overrun, 0);
    lat = 3; cyc(20);

    // R5 16-bit mode ignores upper half
    samp_count = 32'h0001_0003; base = nconv;
    pulse_start();
    wait_done(2000, "R5 16-bit run completes"); cyc(30);
    chk(nconv - base == 3, "R5 upper half ignored", nconv - base, 3);

    // R5 32-bit mode
    cnt32 = 1; samp_count = 32'h0000_0005; base = nconv;
    pulse_start();
    wait_done(2000, "R5 32-bit run completes"); cyc(30);
    chk(nconv - base == 5, "R5 32-bit count", nconv - base, 5);
    cnt32 = 0;

    // R5 zero means 65536 in 16-bit mode
    fast = 1; per = 2; samp_count = 32'h0; base = nconv;
    pulse_start();
    wait_done(140000, "R5 full-range run completes"); cyc(20);
    chk(nconv - base == 65536, "R5 zero count", nconv - base, 65536);
    chk(!overrun, "R9 no overrun at full rate", overrun, 1'b0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule